// File: doc/BRIEF.md
# Stereo Near-Full-Scale Alarm with Retriggered Hold

This block watches a stream of signed stereo capture samples. When the magnitude of the left or the right sample rises above a fixed level just below full scale, it raises a single alarm flag. The level is seven eighths of full scale, about 1.16 dB below maximum swing.

The flag then stays high for a hold time counted in sample periods, 512 by default, which is about 11.6 ms at 44.1 kHz. Each new violation reloads the hold, so a burst of loud material keeps the flag up without gaps. A record-level meter or an indicator lamp can use the flag directly.

Only cycles with the sample strobe high count. Samples and cycles without the strobe neither trigger the flag nor advance the hold.

Top module: `peak_hold_alarm`

## Requirements
- R1: While rst_ni is low, and after reset until the first violating sample, flag_o is 0.
- R2: A valid sample whose left value, read as two's complement, has a magnitude above 0x70000 (with DATA_W=20) sets flag_o to 1 from the clock edge that takes the sample.
- R3: A valid sample whose right value has a magnitude above 0x70000 sets flag_o to 1 in the same way as R2.
- R4: Negative values are judged by magnitude. -0x70001 (0x8FFFF) violates and -0x70000 (0x90000) does not.
- R5: The most negative code 0x80000 counts as a violation. Its magnitude saturates to the largest positive value.
- R6: A magnitude exactly equal to the threshold, 0x70000, does not set the flag. A magnitude of 0x70001 does.
- R7: After the last violating sample, flag_o stays 1 through the next HOLD_LEN-1 (511) non-violating valid samples and returns to 0 on the HOLD_LEN-th (512th).
- R8: A violation while flag_o is high restarts the hold. The flag then lasts HOLD_LEN non-violating valid samples counted from the new violation.
- R9: When valid_i is 0, the sample inputs have no effect. Out-of-range values do not set the flag, and the hold does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe, one cycle per sample period |
| left_i | input | DATA_W | Left sample, two's complement |
| right_i | input | DATA_W | Right sample, two's complement |
| flag_o | output | 1 | Near-full-scale alarm flag |

## Verification
The assertions assume that valid_i and both sample inputs are steady around each rising clock edge. They also assume that valid_i is low while reset is held, so that no sample taken during reset is mistaken for a violation. The bench changes its inputs one time unit after a rising edge and drops valid_i between samples. It also holds valid_i low whenever it pulses reset. Idle cycles with out-of-range data are mixed into the hold window, which tests the premise that only strobed samples count.

// File: rtl/pha_pkg.sv
package pha_pkg;
  // threshold = THR_NUM / 2**THR_SHIFT of full scale (7/8 ~ -1.16 dB)
  localparam int unsigned THR_NUM   = 7;
  localparam int unsigned THR_SHIFT = 3;
  localparam int unsigned NUM_CH    = 2;
endpackage

// File: rtl/pha_mag.sv
module pha_mag #(
  parameter int unsigned   DATA_W = 20,
  parameter logic [DATA_W-1:0] THR = '0
) (
  input  logic [DATA_W-1:0] smp_i,
  output logic              over_o
);
  localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_POS  = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] mag;

  always_comb begin
    if (!smp_i[DATA_W-1])      mag = smp_i;
    else if (smp_i == MIN_CODE) mag = MAX_POS;  // saturate
    else                        mag = ~smp_i + 1'b1;
  end

  assign over_o = (mag > THR);
endmodule

// File: rtl/pha_hold.sv
module pha_hold #(
  parameter int unsigned HOLD_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic hit_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HOLD_LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (hit_i)             cnt_q <= CW'(HOLD_LEN);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/peak_hold_alarm.sv
module peak_hold_alarm #(
  parameter int unsigned DATA_W   = 20,
  parameter int unsigned HOLD_LEN = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              flag_o
);
  import pha_pkg::*;

  localparam logic [DATA_W-1:0] THR =
    DATA_W'(THR_NUM) << (DATA_W - 1 - THR_SHIFT);

  logic [NUM_CH-1:0][DATA_W-1:0] smp;
  logic [NUM_CH-1:0]             over;
  logic                          hit;

  assign smp[0] = left_i;
  assign smp[1] = right_i;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    pha_mag #(.DATA_W(DATA_W), .THR(THR)) u_mag (
      .smp_i (smp[gi]),
      .over_o(over[gi])
    );
  end

  assign hit = |over;

  pha_hold #(.HOLD_LEN(HOLD_LEN)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .hit_i   (hit),
    .active_o(flag_o)
  );
endmodule

// File: rtl/pha_chk.sv
module pha_chk #(
  parameter int unsigned DATA_W   = 20,
  parameter int unsigned HOLD_LEN = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] right_i,
  input logic              flag_o
);
  localparam int unsigned QW = $clog2(HOLD_LEN + 1) + 1;
  localparam logic signed [DATA_W:0] THR_S =
    (DATA_W+1)'(pha_pkg::THR_NUM) << (DATA_W - 1 - pha_pkg::THR_SHIFT);

  logic signed [DATA_W:0] l_s, r_s;
  logic viol;
  logic seen_q;
  logic [QW-1:0] quiet_q;

  assign l_s  = {left_i[DATA_W-1], left_i};
  assign r_s  = {right_i[DATA_W-1], right_i};
  assign viol = valid_i && ((l_s > THR_S) || (l_s < -THR_S) ||
                            (r_s > THR_S) || (r_s < -THR_S));

  // count of quiet strobed samples since the last violation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      quiet_q <= '0;
    end else if (viol) begin
      seen_q  <= 1'b1;
      quiet_q <= '0;
    end else if (valid_i && quiet_q < QW'(HOLD_LEN)) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk_i)
    disable iff (!rst_ni) !seen_q |-> !flag_o);

  assert_set_on_violation_R2: assert property (@(posedge clk_i)
    disable iff (!rst_ni) viol |=> flag_o);

  assert_rise_needs_cause_R3: assert property (@(posedge clk_i)
    disable iff (!rst_ni) $rose(flag_o) |-> $past(viol));

  assert_window_high_R7: assert property (@(posedge clk_i)
    disable iff (!rst_ni) (seen_q && quiet_q < QW'(HOLD_LEN)) |-> flag_o);

  assert_window_low_R8: assert property (@(posedge clk_i)
    disable iff (!rst_ni) (quiet_q >= QW'(HOLD_LEN)) |-> !flag_o);

  assert_idle_stable_R9: assert property (@(posedge clk_i)
    disable iff (!rst_ni) !valid_i |=> $stable(flag_o));
endmodule

bind peak_hold_alarm pha_chk #(.DATA_W(DATA_W), .HOLD_LEN(HOLD_LEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .left_i (left_i),
  .right_i(right_i),
  .flag_o (flag_o)
);

// File: tb/sim_peak_hold_alarm.sv
module sim_peak_hold_alarm;
  localparam int unsigned W    = 20;
  localparam int unsigned HOLD = 512;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [W-1:0] left = '0;
  logic [W-1:0] right = '0;
  logic         flag;
  int           n_chk = 0;
  int           n_err = 0;

  always #5 clk = ~clk;

  peak_hold_alarm #(.DATA_W(W), .HOLD_LEN(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .left_i(left), .right_i(right), .flag_o(flag)
  );

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (flag !== exp) begin
      n_err++;
      $display("FAIL %s: flag_o=%b expected %b at %0t", req, flag, exp, $time);
    end
  endtask

  task automatic push(input logic v, input logic [W-1:0] l, input logic [W-1:0] r);
    valid = v; left = l; right = r;
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) push(1'b1, 20'h00100, 20'hFFF00);
  endtask

  task automatic do_reset();
    valid = 1'b0;
    rst_n = 1'b0;
    #1 check(1'b0, "R1 during reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(1'b0, "R1 after reset");
  endtask

  task automatic t_left();
    do_reset();
    push(1'b1, 20'h70001, 20'h0);
    check(1'b1, "R2 left above threshold");
  endtask

  task automatic t_right();
    do_reset();
    push(1'b1, 20'h0, 20'h7FFFF);
    check(1'b1, "R3 right full scale");
  endtask

  task automatic t_boundary();
    do_reset();
    push(1'b1, 20'h70000, 20'h70000);
    check(1'b0, "R6 equal to threshold");
    push(1'b1, 20'h90000, 20'h90000);
    check(1'b0, "R4 minus threshold");
    push(1'b1, 20'h0, 20'h8FFFF);
    check(1'b1, "R4 minus threshold minus one");
    do_reset();
    push(1'b1, 20'h0, 20'h70001);
    check(1'b1, "R6 threshold plus one");
  endtask

  task automatic t_min_code();
    do_reset();
    push(1'b1, 20'h80000, 20'h0);
    check(1'b1, "R5 most negative code");
  endtask

  task automatic t_idle();
    do_reset();
    push(1'b0, 20'h80000, 20'h7FFFF);
    push(1'b0, 20'h7FFFF, 20'h80000);
    check(1'b0, "R9 unstrobed violation ignored");
  endtask

  task automatic t_hold();
    do_reset();
    push(1'b1, 20'h7FFFF, 20'h0);
    quiet(300);
    for (int i = 0; i < 50; i++) push(1'b0, 20'h0, 20'h0);
    quiet(211);
    check(1'b1, "R7 high after 511 quiet samples");
    for (int i = 0; i < 20; i++) push(1'b0, 20'h80000, 20'h0);
    check(1'b1, "R9 idle cycles do not advance hold");
    quiet(1);
    check(1'b0, "R7 low after 512th quiet sample");
  endtask

  task automatic t_retrig();
    do_reset();
    push(1'b1, 20'h70001, 20'h0);
    quiet(300);
    push(1'b1, 20'h0, 20'h80000);
    quiet(212);
    check(1'b1, "R8 old window end passes with flag high");
    quiet(299);
    check(1'b1, "R8 high after 511 since retrigger");
    quiet(1);
    check(1'b0, "R8 low after 512 since retrigger");
  endtask

  initial begin
    #2_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: run timed out, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_left();
    t_right();
    t_boundary();
    t_min_code();
    t_idle();
    t_hold();
    t_retrig();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule